// File: doc/BRIEF.md
# Register Lock Hazard Interlock

This block keeps the lock state of every single-precision register used by a floating-point coprocessor pipeline. Arithmetic operations pass through Fetch, Decode and four execute stages (E1 to E4). Loads and stores pass through Fetch, Decode, E, M and W. When an operation leaves Fetch and decodes, its source registers and its destination registers are marked as locked. An instruction that touches a locked register in a way that could go wrong is held in Fetch. A held instruction is one that reads a pending result, overwrites a register still needed as a source, overwrites a pending result, or accesses a register that an earlier operation still protects as a source. Instructions that move the status flags to the host are held the same way until an earlier compare has written the condition codes.

Locks are released by per-cycle events from the pipeline, not when a whole instruction finishes. Each iteration of a vector operation releases its source registers in its first E1 cycle. Each destination is released in the next-to-last execute cycle. A load-multiple releases one target per W cycle. So a consumer waits only for the registers it really uses. The cycle after a destination release, the result is on the forwarding path. A consumer that decodes in that cycle and reads that register sees the forward-valid output go high.

The fetch stage shows its candidate instruction as register bitmasks. The stall output always gives the hazard state of the candidate shown. The candidate decodes in a cycle where it is marked valid and the stall is low.

Top module: `reg_lock_interlock`

## Requirements
- R1: After a cycle with `rst` high, every source, destination and flag lock is clear, so no candidate mask stalls and `fwd_valid` is low.
- R2: In a cycle where `cand_valid` is 1 and `fetch_stall` is 0, the candidate decodes. From the next cycle on, each bit of `cand_src` is source-locked, each bit of `cand_dst` is destination-locked, and `cand_is_cmp` sets the flag lock.
- R3: `fetch_stall` is 1 in any cycle where a bit of `cand_src` (bit i = register i) is destination-locked.
- R4: `fetch_stall` is 1 in any cycle where a bit of `cand_src` or `cand_dst` is source-locked.
- R5: `fetch_stall` is 1 in any cycle where a bit of `cand_dst` is destination-locked.
- R6: A bit of `src_rel_mask` clears that register's source lock from the next cycle on. It does not touch destination locks. A source lock with no release stays set.
- R7: A bit of `dst_rel_mask` clears that register's destination lock from the next cycle on. It does not touch source locks.
- R8: If a decode sets a lock in the same cycle that a release clears it, the lock stays set.
- R9: `fwd_valid` is 1 exactly in a decode cycle where `cand_src` has a bit that was set in `dst_rel_mask` in the previous cycle.
- R10: While the flag lock is set, a candidate with `cand_needs_flags` stalls. `flags_done` clears the flag lock from the next cycle on, and a compare decoding in the same cycle wins.
- R11: With a load-multiple releasing one target per cycle, a consumer of one target decodes the cycle after that target is released, while later targets are still locked.
- R12: A multiply that decodes in cycle N, with its destination released in its E3 cycle (N+3), makes a dependent add stall for exactly three cycles. The add then decodes in cycle N+4 with `fwd_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | An instruction sits in Fetch and wants to decode |
| cand_src | input | NREG | Registers the candidate reads (bit i = register i) |
| cand_dst | input | NREG | Registers the candidate writes |
| cand_is_cmp | input | 1 | Candidate is a compare that will write the condition codes |
| cand_needs_flags | input | 1 | Candidate moves the condition codes to the host |
| src_rel_mask | input | NREG | Source locks to release (first E1 of an operation or iteration) |
| dst_rel_mask | input | NREG | Destination locks to release (E3, or one W transfer) |
| flags_done | input | 1 | The pending compare has written the condition codes |
| fetch_stall | output | 1 | Hold the candidate in Fetch |
| fwd_valid | output | 1 | The decoding candidate takes an operand from the forwarding path |

## Verification
Random sparse candidate masks, mixed with random partial releases, check all three hazard kinds against a bench model. That model tells apart which lock vector a release may touch. Directed sequences replay the multiply-to-add dependency and the per-register load-multiple release, which shows that a consumer waits on one target and not the whole transfer. Further directed cases put a set and a clear on the same register in the same cycle, and separate a read of a source-locked register from a read of a destination-locked one. A compare followed by a flag move checks the flag interlock.

// File: rtl/rli_pkg.sv
package rli_pkg;

  localparam int RLI_NREG_DEFAULT = 32;

  typedef struct packed {
    logic raw;
    logic war;
    logic waw;
    logic held;
    logic flag;
  } rli_cause_t;

endpackage

// File: rtl/rli_lock_bank.sv
module rli_lock_bank #(
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] set_mask,
  input  logic [NREG-1:0] clr_mask,
  output logic [NREG-1:0] lock
);

  for (genvar i = 0; i < NREG; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        lock[i] <= 1'b0;
      end else if (set_mask[i]) begin
        lock[i] <= 1'b1;
      end else if (clr_mask[i]) begin
        lock[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rli_flag_lock.sv
module rli_flag_lock (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic lock
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock <= 1'b0;
    end else if (set_i) begin
      lock <= 1'b1;
    end else if (clr_i) begin
      lock <= 1'b0;
    end
  end

endmodule

// File: rtl/rli_hazard.sv
module rli_hazard
  import rli_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic [NREG-1:0] cand_src,
  input  logic [NREG-1:0] cand_dst,
  input  logic            cand_needs_flags,
  input  logic [NREG-1:0] src_lock,
  input  logic [NREG-1:0] dst_lock,
  input  logic            flag_lock,
  output rli_cause_t      cause,
  output logic            stall
);

  always_comb begin
    cause.raw  = |(cand_src & dst_lock);
    cause.war  = |(cand_dst & src_lock);
    cause.waw  = |(cand_dst & dst_lock);
    cause.held = |(cand_src & src_lock);
    cause.flag = cand_needs_flags & flag_lock;
    stall      = cause.raw | cause.war | cause.waw | cause.held | cause.flag;
  end

endmodule

// File: rtl/rli_forward.sv
module rli_forward #(
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] dst_rel_mask,
  input  logic [NREG-1:0] cand_src,
  input  logic            decode,
  output logic            fwd_valid
);

  logic [NREG-1:0] rel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q <= '0;
    end else begin
      rel_q <= dst_rel_mask;
    end
  end

  assign fwd_valid = decode & (|(cand_src & rel_q));

endmodule

// File: rtl/reg_lock_interlock.sv
module reg_lock_interlock
  import rli_pkg::*;
#(
  parameter int NREG = rli_pkg::RLI_NREG_DEFAULT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cand_valid,
  input  logic [NREG-1:0] cand_src,
  input  logic [NREG-1:0] cand_dst,
  input  logic            cand_is_cmp,
  input  logic            cand_needs_flags,
  input  logic [NREG-1:0] src_rel_mask,
  input  logic [NREG-1:0] dst_rel_mask,
  input  logic            flags_done,
  output logic            fetch_stall,
  output logic            fwd_valid
);

  logic [NREG-1:0] src_lock;
  logic [NREG-1:0] dst_lock;
  logic            flag_lock;
  logic            decode;
  logic [NREG-1:0] src_set;
  logic [NREG-1:0] dst_set;
  rli_cause_t      cause;

  assign decode  = cand_valid & ~fetch_stall;
  assign src_set = decode ? cand_src : '0;
  assign dst_set = decode ? cand_dst : '0;

  rli_lock_bank #(.NREG(NREG)) u_src_bank (
    .clk      (clk),
    .rst      (rst),
    .set_mask (src_set),
    .clr_mask (src_rel_mask),
    .lock     (src_lock)
  );

  rli_lock_bank #(.NREG(NREG)) u_dst_bank (
    .clk      (clk),
    .rst      (rst),
    .set_mask (dst_set),
    .clr_mask (dst_rel_mask),
    .lock     (dst_lock)
  );

  rli_flag_lock u_flag (
    .clk   (clk),
    .rst   (rst),
    .set_i (decode & cand_is_cmp),
    .clr_i (flags_done),
    .lock  (flag_lock)
  );

  rli_hazard #(.NREG(NREG)) u_hazard (
    .cand_src         (cand_src),
    .cand_dst         (cand_dst),
    .cand_needs_flags (cand_needs_flags),
    .src_lock         (src_lock),
    .dst_lock         (dst_lock),
    .flag_lock        (flag_lock),
    .cause            (cause),
    .stall            (fetch_stall)
  );

  rli_forward #(.NREG(NREG)) u_fwd (
    .clk          (clk),
    .rst          (rst),
    .dst_rel_mask (dst_rel_mask),
    .cand_src     (cand_src),
    .decode       (decode),
    .fwd_valid    (fwd_valid)
  );

endmodule

// File: rtl/rli_checker.sv
module rli_checker #(
  parameter int NREG = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            cand_valid,
  input logic [NREG-1:0] cand_src,
  input logic [NREG-1:0] cand_dst,
  input logic            cand_is_cmp,
  input logic [NREG-1:0] src_rel_mask,
  input logic [NREG-1:0] src_lock,
  input logic [NREG-1:0] dst_lock,
  input logic            flag_lock,
  input logic            fetch_stall,
  input logic            fwd_valid
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !fetch_stall && !fwd_valid); // R1

  AST_RAW_STALLS: assert property (@(posedge clk) disable iff (rst)
    (|(cand_src & dst_lock)) |-> fetch_stall); // R3

  AST_SRC_HELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(src_lock) & ~$past(src_rel_mask)) & ~src_lock) == '0)); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (cand_valid && !fetch_stall) |=> ((($past(cand_dst) & ~dst_lock) == '0) &&
                                      (($past(cand_src) & ~src_lock) == '0))); // R8

  AST_FWD_ON_DECODE: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> (cand_valid && !fetch_stall)); // R9

  AST_CMP_LOCKS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (cand_valid && !fetch_stall && cand_is_cmp) |=> flag_lock); // R10

endmodule

bind reg_lock_interlock rli_checker #(.NREG(NREG)) u_rli_checker (
  .clk          (clk),
  .rst          (rst),
  .cand_valid   (cand_valid),
  .cand_src     (cand_src),
  .cand_dst     (cand_dst),
  .cand_is_cmp  (cand_is_cmp),
  .src_rel_mask (src_rel_mask),
  .src_lock     (src_lock),
  .dst_lock     (dst_lock),
  .flag_lock    (flag_lock),
  .fetch_stall  (fetch_stall),
  .fwd_valid    (fwd_valid)
);

// File: tb/tb_reg_lock_interlock.sv
`timescale 1ns/1ps
module tb_reg_lock_interlock;

  localparam int NREG = 32;

  logic            clk = 1'b0;
  logic            rst;
  logic            cand_valid;
  logic [NREG-1:0] cand_src;
  logic [NREG-1:0] cand_dst;
  logic            cand_is_cmp;
  logic            cand_needs_flags;
  logic [NREG-1:0] src_rel_mask;
  logic [NREG-1:0] dst_rel_mask;
  logic            flags_done;
  logic            fetch_stall;
  logic            fwd_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [NREG-1:0] m_src, m_dst, m_rel;
  logic            m_flag;
  logic            last_stall;

  always #10 clk = ~clk;

  reg_lock_interlock #(.NREG(NREG)) dut (
    .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_src(cand_src),
    .cand_dst(cand_dst), .cand_is_cmp(cand_is_cmp), .cand_needs_flags(cand_needs_flags),
    .src_rel_mask(src_rel_mask), .dst_rel_mask(dst_rel_mask), .flags_done(flags_done),
    .fetch_stall(fetch_stall), .fwd_valid(fwd_valid)
  );

  function automatic logic exp_stall(logic [NREG-1:0] s, logic [NREG-1:0] d, logic nf);
    return (|(s & m_dst)) | (|((s | d) & m_src)) | (|(d & m_dst)) | (nf & m_flag);
  endfunction

  function automatic logic [NREG-1:0] rbits();
    logic [NREG-1:0] m = '0;
    int n = 1 + int'($urandom % 3);
    for (int k = 0; k < n; k++) m |= (32'b1 << ($urandom % NREG));
    return m;
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic cyc(logic v, logic [NREG-1:0] s, logic [NREG-1:0] d, logic cmp, logic nf,
                     logic [NREG-1:0] sr, logic [NREG-1:0] dr, logic fd, string tag);
    logic es, ef;
    @(negedge clk);
    cand_valid = v; cand_src = s; cand_dst = d; cand_is_cmp = cmp; cand_needs_flags = nf;
    src_rel_mask = sr; dst_rel_mask = dr; flags_done = fd;
    #1;
    es = exp_stall(s, d, nf);
    ef = v & ~es & (|(s & m_rel));
    check(tag, fetch_stall, es, "fetch_stall");
    check(tag, fwd_valid, ef, "fwd_valid");
    last_stall = fetch_stall;
    @(posedge clk);
    m_src  = (m_src & ~sr) | ((v & ~es) ? s : '0);
    m_dst  = (m_dst & ~dr) | ((v & ~es) ? d : '0);
    m_flag = ((v & ~es & cmp) ? 1'b1 : (fd ? 1'b0 : m_flag));
    m_rel  = dr;
  endtask

  task automatic idle_probe(logic [NREG-1:0] s, logic [NREG-1:0] d, logic nf, string tag);
    cyc(1'b0, s, d, 1'b0, nf, '0, '0, 1'b0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_src = '0; m_dst = '0; m_rel = '0; m_flag = 1'b0;
  endtask

  initial begin
    int stalls;
    void'($urandom(32'd2024));
    rst = 1'b1; cand_valid = 0; cand_src = '0; cand_dst = '0; cand_is_cmp = 0;
    cand_needs_flags = 0; src_rel_mask = '0; dst_rel_mask = '0; flags_done = 0;
    m_src = '0; m_dst = '0; m_rel = '0; m_flag = 1'b0;
    do_reset();

    // R1: nothing locked after reset
    idle_probe('1, '1, 1'b1, "R1");

    // R12: multiply decodes, dependent add waits three cycles, then forwards
    cyc(1, 32'h6, 32'h8, 0, 0, '0, '0, 0, "R2");          // mul s1,s2 -> s3
    stalls = 0;
    cyc(1, 32'h18, 32'h20, 0, 0, 32'h6, '0, 0, "R12");    // E1: release sources
    if (last_stall) stalls++;
    cyc(1, 32'h18, 32'h20, 0, 0, '0, '0, 0, "R12");       // E2
    if (last_stall) stalls++;
    cyc(1, 32'h18, 32'h20, 0, 0, '0, 32'h8, 0, "R12");    // E3: release destination
    if (last_stall) stalls++;
    @(negedge clk);
    cand_valid = 1; cand_src = 32'h18; cand_dst = 32'h20; src_rel_mask = '0; dst_rel_mask = '0;
    #1;
    check("R12", 1'(stalls == 3), 1'b1, "three stall cycles");
    check("R12", fwd_valid, 1'b1, "fwd_valid at add decode");
    check("R9", fetch_stall, 1'b0, "fetch_stall at add decode");
    @(posedge clk);
    m_src |= 32'h18; m_dst |= 32'h20; m_rel = '0;
    do_reset();

    // R4 / R6 / R5 / R7: source vs destination lock release
    cyc(1, 32'h100, 32'h200, 0, 0, '0, '0, 0, "R2");      // reads r8, writes r9
    idle_probe('0, 32'h100, 0, "R4");                     // write of source-locked r8
    idle_probe(32'h100, '0, 0, "R4");                     // read of source-locked r8
    idle_probe('0, 32'h200, 0, "R5");                     // write of dest-locked r9
    idle_probe(32'h200, '0, 0, "R3");                     // read of dest-locked r9
    cyc(0, '0, '0, 0, 0, 32'h300, '0, 0, "R6");           // release sources r8,r9
    idle_probe('0, 32'h100, 0, "R6");                     // r8 free
    idle_probe(32'h200, '0, 0, "R6");                     // r9 dest lock survives
    cyc(0, '0, '0, 0, 0, '0, 32'h300, 0, "R7");
    idle_probe(32'h200, 32'h100, 0, "R7");
    do_reset();

    // R8: set and clear on same register in same cycle
    cyc(1, 32'h800, 32'h400, 0, 0, 32'h800, 32'h400, 0, "R8");
    idle_probe(32'h400, '0, 0, "R8");
    idle_probe('0, 32'h800, 0, "R8");
    do_reset();

    // R10: compare then flag move
    cyc(1, 32'h1, '0, 1, 0, '0, '0, 0, "R10");
    cyc(1, '0, '0, 0, 1, 32'h1, '0, 0, "R10");
    cyc(1, '0, '0, 0, 1, '0, '0, 1, "R10");
    cyc(1, '0, '0, 0, 1, '0, '0, 0, "R10");
    cyc(1, '0, '0, 1, 0, '0, '0, 1, "R10");               // compare wins over done
    idle_probe('0, '0, 1, "R10");
    do_reset();

    // R11: load-multiple releasing one target per W cycle
    cyc(1, '0, 32'hF000, 0, 0, '0, '0, 0, "R2");          // load r12..r15
    cyc(1, 32'h2000, 32'h1, 0, 0, '0, '0, 0, "R11");      // consumer of r13 waits
    cyc(1, 32'h2000, 32'h1, 0, 0, '0, 32'h1000, 0, "R11");
    cyc(1, 32'h2000, 32'h1, 0, 0, '0, 32'h2000, 0, "R11");
    cyc(1, 32'h2000, 32'h1, 0, 0, '0, 32'h4000, 0, "R11"); // decodes with forward
    idle_probe('0, 32'h8000, 0, "R11");                   // r15 still locked
    do_reset();

    // Random traffic: R3 stall model, R9 forwarding
    for (int n = 0; n < 3000; n++) begin
      cyc(($urandom % 4) != 0, rbits(), rbits(), ($urandom % 8) == 0, ($urandom % 8) == 0,
          m_src & 32'($urandom), m_dst & 32'($urandom), ($urandom % 4) == 0, "R3");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int w = 0; w < 200000; w++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule